// File: doc/BRIEF.md
# Machine Clock Source Switch Controller

This block decides whether the machine clock comes from the main oscillator, divided by two, or from a multiplied PLL output. It runs on the oscillator clock and is programmed through a small register written with a single-cycle write strobe. The register holds a source-select bit (1 = main, 0 = PLL), a two-bit PLL multiplier field and a two-bit wait-select field. It also shows a read-only status bit that tells whether the main clock is still driving the machine clock.

When software clears the source-select bit, the block first clears an external timebase counter and its overflow flag with one-cycle pulses. It then keeps the main clock in use for a stabilization wait counted in oscillator cycles. Only when the wait has run out does it switch its select output over to the PLL. The wait has a fixed length when coming from main-clock mode. When the sub-clock-mode input is high, the length comes from the wait-select field instead. Setting the bit back to 1 returns to the main clock at once and cancels any wait. The multiplier field can only be changed while the main clock is both requested and running.

Top module: `mclk_src_ctrl`

## Requirements
- R1: After reset the source-select bit is 1, the multiplier and wait-select fields are 00, the main-running status is 1, and both clear pulses are low. Readback layout of `rd_data`: bit 0 is source select, bits 2:1 are the multiplier, bits 4:3 are wait select, bit 5 is main-running status, and all other bits are 0.
- R2: While main-running is 1, `main_ce` alternates its value every oscillator cycle, giving one enable per two cycles. While main-running is 0, `main_ce` is 0.
- R3: A write that changes source select from 1 to 0 with `sub_mode` low keeps main-running at 1 and `pll_sel` at 0 for 2^FIX_LOG cycles after the write edge. Both then change on that edge: main-running drops to 0 and `pll_sel` rises to 1.
- R4: With `sub_mode` high at the 1-to-0 write, the wait length comes from the wait-select value held before that write. The values 0, 1, 2 and 3 give 2^SEL0_LOG, 2^SEL1_LOG, 2^SEL2_LOG and 2^SEL3_LOG cycles.
- R5: A 1-to-0 write of source select raises `tb_cnt_clr` and `tb_flag_clr` together for exactly the one cycle after the write edge.
- R6: A write to the multiplier field is ignored when, before the write, source select is 0 or main-running is 0. Otherwise the field takes the written value and drives `pll_mult`.
- R7: A write that changes source select from 0 to 1 sets main-running to 1 and `pll_sel` to 0 on its own edge. It cancels any wait in progress.
- R8: A write of 0 while source select already holds 0 produces no clear pulse, does not restart or lengthen a running wait, and leaves `pll_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| sub_mode | input | 1 | High when the part is running from the sub clock |
| rd_data | output | REG_W | Register readback |
| pll_sel | output | 1 | 1 when the PLL drives the machine clock |
| pll_mult | output | 2 | Selected PLL multiplication rate |
| main_ce | output | 1 | Divide-by-two enable for the main clock |
| tb_cnt_clr | output | 1 | One-cycle clear for the timebase counter |
| tb_flag_clr | output | 1 | One-cycle clear for the timebase overflow flag |

## Verification
Register fields and the main-running status settle on the write edge itself and are read at the falling edge that follows. The clear pulses appear in that same half cycle and are gone one cycle later. The PLL switch lands exactly N edges after the write edge, so the bench counts falling edges from the one after the write until the status drops, and compares the count with N. The bench is built with short wait lengths so that every selection can be timed exactly. Writes issued during a running wait are counted inside that tally, so the fall must still land on the original cycle.

// File: rtl/mclk_src_pkg.sv
package mclk_src_pkg;

    // Programmable fields; the first member is the most significant.
    typedef struct packed {
        logic [1:0] wait_sel;
        logic [1:0] mult;
        logic       src_main;
    } mclk_cfg_t;

    localparam int CFG_W = $bits(mclk_cfg_t);

    localparam mclk_cfg_t CFG_RESET = '{wait_sel: 2'b00, mult: 2'b00, src_main: 1'b1};

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mclk_cfg_reg.sv
module mclk_cfg_reg
    import mclk_src_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             main_run,
    output mclk_cfg_t        cfg,
    output logic             start_pll,
    output logic             back_main,
    output logic             tb_cnt_clr,
    output logic             tb_flag_clr,
    output logic [REG_W-1:0] rd_data
);

    mclk_cfg_t wcfg;
    logic      mult_ok;
    logic      unused_hi;

    assign wcfg      = mclk_cfg_t'(wr_data[CFG_W-1:0]);
    assign unused_hi = ^wr_data[REG_W-1:CFG_W];

    assign start_pll = wr_en &  cfg.src_main & ~wcfg.src_main;
    assign back_main = wr_en & ~cfg.src_main &  wcfg.src_main;
    assign mult_ok   = cfg.src_main & main_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg         <= CFG_RESET;
            tb_cnt_clr  <= 1'b0;
            tb_flag_clr <= 1'b0;
        end else begin
            tb_cnt_clr  <= start_pll;
            tb_flag_clr <= start_pll;
            if (wr_en) begin
                cfg.src_main <= wcfg.src_main;
                cfg.wait_sel <= wcfg.wait_sel;
                if (mult_ok) begin
                    cfg.mult <= wcfg.mult;
                end
            end
        end
    end

    always_comb begin
        rd_data            = '0;
        rd_data[CFG_W-1:0] = cfg;
        rd_data[CFG_W]     = main_run;
    end

    assert_clr_after_start_R5: assert property (@(posedge clk) disable iff (rst)
        tb_cnt_clr |-> (!cfg.src_main && tb_flag_clr));

    assert_clr_single_R5: assert property (@(posedge clk) disable iff (rst)
        tb_cnt_clr |=> !tb_cnt_clr);

    assert_mult_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg.src_main || !main_run) |=> $stable(cfg.mult));

    assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
        back_main |=> main_run);

    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg.src_main && !wcfg.src_main) |=> (!tb_cnt_clr && !tb_flag_clr));

endmodule

// File: rtl/mclk_stab_timer.sv
module mclk_stab_timer
    import mclk_src_pkg::*;
#(
    parameter int FIX_LOG  = 14,
    parameter int SEL0_LOG = 10,
    parameter int SEL1_LOG = 13,
    parameter int SEL2_LOG = 15,
    parameter int SEL3_LOG = 17,
    parameter int CNT_W    = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_pll,
    input  logic       back_main,
    input  logic       sub_mode,
    input  logic [1:0] wait_sel,
    output logic       main_run
);

    localparam logic [CNT_W-1:0] LEN_FIX = CNT_W'(1) << FIX_LOG;
    localparam logic [CNT_W-1:0] LEN_S0  = CNT_W'(1) << SEL0_LOG;
    localparam logic [CNT_W-1:0] LEN_S1  = CNT_W'(1) << SEL1_LOG;
    localparam logic [CNT_W-1:0] LEN_S2  = CNT_W'(1) << SEL2_LOG;
    localparam logic [CNT_W-1:0] LEN_S3  = CNT_W'(1) << SEL3_LOG;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_len;
    logic             busy;

    always_comb begin
        if (!sub_mode) begin
            load_len = LEN_FIX;
        end else begin
            case (wait_sel)
                2'd0:    load_len = LEN_S0;
                2'd1:    load_len = LEN_S1;
                2'd2:    load_len = LEN_S2;
                default: load_len = LEN_S3;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt      <= '0;
            main_run <= 1'b1;
        end else if (back_main) begin
            busy     <= 1'b0;
            cnt      <= '0;
            main_run <= 1'b1;
        end else if (start_pll) begin
            busy     <= 1'b1;
            cnt      <= load_len;
        end else if (busy) begin
            if (cnt == CNT_W'(1)) begin
                busy     <= 1'b0;
                main_run <= 1'b0;
            end else begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assert_fall_at_expiry_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(main_run) |-> ($past(busy) && ($past(cnt) == CNT_W'(1))));

    assert_hold_main_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> main_run);

    assert_start_loads_R4: assert property (@(posedge clk) disable iff (rst)
        (start_pll && !back_main) |=> (busy && cnt != '0));

endmodule

// File: rtl/mclk_main_div.sv
module mclk_main_div (
    input  logic clk,
    input  logic rst,
    input  logic main_run,
    output logic main_ce
);

    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    assign main_ce = phase & main_run;

    assert_alternate_R2: assert property (@(posedge clk) disable iff (rst)
        (main_run && $past(main_run) && !$past(rst)) |-> (main_ce != $past(main_ce)));

endmodule

// File: rtl/mclk_src_ctrl.sv
module mclk_src_ctrl
    import mclk_src_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int FIX_LOG  = 14,
    parameter int SEL0_LOG = 10,
    parameter int SEL1_LOG = 13,
    parameter int SEL2_LOG = 15,
    parameter int SEL3_LOG = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sub_mode,
    output logic [REG_W-1:0] rd_data,
    output logic             pll_sel,
    output logic [1:0]       pll_mult,
    output logic             main_ce,
    output logic             tb_cnt_clr,
    output logic             tb_flag_clr
);

    localparam int MAX_LOG = max_int(max_int(FIX_LOG, SEL0_LOG),
                                     max_int(max_int(SEL1_LOG, SEL2_LOG), SEL3_LOG));
    localparam int CNT_W   = MAX_LOG + 1;

    mclk_cfg_t cfg;
    logic      main_run;
    logic      start_pll;
    logic      back_main;

    mclk_cfg_reg #(
        .REG_W (REG_W)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .main_run    (main_run),
        .cfg         (cfg),
        .start_pll   (start_pll),
        .back_main   (back_main),
        .tb_cnt_clr  (tb_cnt_clr),
        .tb_flag_clr (tb_flag_clr),
        .rd_data     (rd_data)
    );

    mclk_stab_timer #(
        .FIX_LOG  (FIX_LOG),
        .SEL0_LOG (SEL0_LOG),
        .SEL1_LOG (SEL1_LOG),
        .SEL2_LOG (SEL2_LOG),
        .SEL3_LOG (SEL3_LOG),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_pll (start_pll),
        .back_main (back_main),
        .sub_mode  (sub_mode),
        .wait_sel  (cfg.wait_sel),
        .main_run  (main_run)
    );

    mclk_main_div u_div (
        .clk      (clk),
        .rst      (rst),
        .main_run (main_run),
        .main_ce  (main_ce)
    );

    assign pll_sel  = ~main_run;
    assign pll_mult = cfg.mult;

    assert_pll_needs_request_R3: assert property (@(posedge clk) disable iff (rst)
        pll_sel |-> !cfg.src_main);

    assert_ce_off_in_pll_R2: assert property (@(posedge clk) disable iff (rst)
        pll_sel |-> !main_ce);

endmodule

// File: tb/sim_mclk_src_ctrl.sv
module sim_mclk_src_ctrl;

    localparam int REG_W = 8;
    localparam int FIXL  = 6;
    localparam int S0L = 2, S1L = 3, S2L = 4, S3L = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic             sub_mode = 1'b0;
    logic [REG_W-1:0] rd_data;
    logic             pll_sel;
    logic [1:0]       pll_mult;
    logic             main_ce;
    logic             tb_cnt_clr;
    logic             tb_flag_clr;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mclk_src_ctrl #(
        .REG_W (REG_W), .FIX_LOG (FIXL),
        .SEL0_LOG (S0L), .SEL1_LOG (S1L), .SEL2_LOG (S2L), .SEL3_LOG (S3L)
    ) u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .sub_mode (sub_mode), .rd_data (rd_data), .pll_sel (pll_sel),
        .pll_mult (pll_mult), .main_ce (main_ce),
        .tb_cnt_clr (tb_cnt_clr), .tb_flag_clr (tb_flag_clr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write strobe in the cycle after the next falling edge; returns just after the write edge.
    task automatic wr(input logic src, input logic [1:0] mult, input logic [1:0] ws);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {3'b000, ws, mult, src};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Count falling edges until main-running drops; called just after the write edge.
    task automatic measure(input int exp, input string req);
        int n = 0;
        while (rd_data[5] && n < 5000) begin
            @(negedge clk);
            n++;
            if (n == 1) check({req, " clear pulse is single (R5)"}, tb_cnt_clr | tb_flag_clr, 0);
        end
        check({req, " wait length"}, n, exp);
        check({req, " pll_sel after wait"}, pll_sel, 1);
    endtask

    task automatic t_reset;
        check("R1 readback after reset", rd_data, 8'h21);
        check("R1 pll_sel after reset", pll_sel, 0);
        check("R1 pll_mult after reset", pll_mult, 0);
        check("R1 clears idle after reset", tb_cnt_clr | tb_flag_clr, 0);
    endtask

    task automatic t_main_div;
        logic prev = main_ce;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R2 main_ce alternates", main_ce, !prev);
            prev = main_ce;
        end
    endtask

    task automatic t_mult_main;
        wr(1'b1, 2'b10, 2'b00);
        check("R6 multiplier writable in main mode", pll_mult, 2);
        check("R6 readback multiplier field", rd_data[2:1], 2);
    endtask

    task automatic t_fixed_wait;
        sub_mode = 1'b0;
        wr(1'b0, 2'b10, 2'b00);
        check("R5 counter clear pulse", tb_cnt_clr, 1);
        check("R5 flag clear pulse", tb_flag_clr, 1);
        check("R3 main still running at write", rd_data[5], 1);
        measure(1 << FIXL, "R3 fixed");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 main_ce low under PLL", main_ce, 0);
        end
    endtask

    task automatic t_locked_and_repeat;
        wr(1'b0, 2'b11, 2'b00);
        check("R6 multiplier locked under PLL", pll_mult, 2);
        check("R8 no clear on repeated 0", tb_cnt_clr | tb_flag_clr, 0);
        check("R8 pll_sel unchanged", pll_sel, 1);
    endtask

    task automatic t_abort;
        wr(1'b1, 2'b10, 2'b00);
        check("R7 main restored on write edge", rd_data[5], 1);
        check("R7 pll_sel cleared", pll_sel, 0);
        // Abort in the middle of a wait.
        wr(1'b0, 2'b10, 2'b00);
        repeat (5) @(negedge clk);
        wr(1'b1, 2'b10, 2'b00);
        check("R7 abort keeps main", rd_data[5], 1);
        repeat ((1 << FIXL) + 16) @(negedge clk);
        check("R7 aborted wait never switches", pll_sel, 0);
    endtask

    task automatic t_no_restart;
        wr(1'b0, 2'b10, 2'b00);
        repeat (10) @(negedge clk);
        wr(1'b0, 2'b01, 2'b00);
        check("R6 multiplier locked during wait", pll_mult, 2);
        check("R8 no clear on write during wait", tb_cnt_clr | tb_flag_clr, 0);
        measure((1 << FIXL) - 12, "R8 wait not restarted");
        wr(1'b1, 2'b10, 2'b00);
    endtask

    task automatic t_sub_waits;
        int lens[4];
        lens[0] = 1 << S0L; lens[1] = 1 << S1L; lens[2] = 1 << S2L; lens[3] = 1 << S3L;
        sub_mode = 1'b1;
        for (int ws = 0; ws < 4; ws++) begin
            wr(1'b1, 2'b10, 2'(ws));
            check("R1 readback wait-select field", rd_data[4:3], ws);
            wr(1'b0, 2'b10, 2'(ws));
            measure(lens[ws], "R4 selected");
            wr(1'b1, 2'b10, 2'(ws));
        end
        sub_mode = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_main_div;
        t_mult_main;
        t_fixed_wait;
        t_locked_and_repeat;
        t_abort;
        t_no_restart;
        t_sub_waits;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule